// File: doc/BRIEF.md
# Priority Threshold Interrupt Selector

This block picks the interrupt that one target context should service next. It receives one bit per source for pending, claimed and enabled, a 3-bit priority per source and the threshold of the context. From these it produces a registered interrupt request and the identifier of the winning source. Pending and claimed state are held outside the block, together with any bus access. A system with several contexts instantiates the block once per context.

A source qualifies when three things hold: it is pending, it is not claimed, and it is enabled. Its priority must also be strictly above the context threshold. Among the qualifying sources, the highest priority wins, and a tie goes to the lower source number. Source 0 is reserved, so a reported identifier of 0 means that no source qualifies.

Inside the block the bit vectors are split into 32-source words. Each word is reduced by a comparison tree, and a second tree then chooses among the word winners. The result is registered, so it describes the inputs as they were sampled at the previous clock edge.

Top module: `irq_prio_sel`

## Requirements
- R1: A source takes part only when its pending bit (bit s of `pend_i`) is 1, its claimed bit (bit s of `claim_i`) is 0 and its enable bit (bit s of `en_i`) is 1.
- R2: A source takes part only when its priority is strictly greater than `thr_i`. A priority equal to the threshold does not raise the request.
- R3: `irq_o` is 1 exactly when at least one source satisfies both R1 and R2.
- R4: `id_o` is the number of the qualifying source with the highest priority.
- R5: When several qualifying sources share the highest priority, `id_o` is the lowest of their numbers.
- R6: When no source qualifies, `id_o` is 0.
- R7: Source 0 is never selected, whatever its input bits and priority.
- R8: `irq_o` and `id_o` show the result for the inputs sampled at the previous rising clock edge. Input changes between edges do not affect them. `valid_o` goes to 1 at the first rising edge after reset is released and then stays at 1.
- R9: While `rst_ni` is low, `irq_o`, `id_o` and `valid_o` are all 0.
- R10: The priority of source s is held in `prio_i[3*s+2:3*s]`. Sources in every word can win, including the top source NUM_SRC-1 in a partly filled last word.

Two parameters shape the block. `NUM_SRC` sets the number of sources and defaults to 53. `ID_W` is derived from it as ceil(log2(NUM_SRC)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_SRC | Pending bit per source |
| claim_i | input | NUM_SRC | Claimed bit per source |
| en_i | input | NUM_SRC | Enable bit per source for this context |
| prio_i | input | 3*NUM_SRC | 3-bit priority per source |
| thr_i | input | 3 | Context threshold |
| irq_o | output | 1 | Interrupt request level |
| id_o | output | ID_W | Winning source, 0 when none |
| valid_o | output | 1 | Result register holds a computed result |

## Verification
The bench sets a source priority equal to the threshold. A design that used greater-or-equal there would raise the request. It builds ties between sources in different words. A tree that favoured the right-hand child would report the higher-numbered source. It drives source 0 at maximum priority, where a design that did not mask source 0 would report identifier 0 together with a raised request. It also selects the top source in the partly filled last word, which catches wrong padding or wrong priority slicing. Random patterns of differing density then compare both outputs against a sequential upward scan.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned WORD_W = 32;

  typedef logic [PRIO_W-1:0] prio_t;

  // right (higher-numbered) candidate replaces left only on strictly higher priority
  function automatic logic right_wins(logic l_vld, prio_t l_prio, logic r_vld, prio_t r_prio);
    return r_vld && (!l_vld || (r_prio > l_prio));
  endfunction
endpackage

// File: rtl/irq_word_mask.sv
module irq_word_mask
  import irq_sel_pkg::*;
#(
  parameter int unsigned BASE = 0
) (
  input  logic [WORD_W-1:0]        pend_i,
  input  logic [WORD_W-1:0]        claim_i,
  input  logic [WORD_W-1:0]        en_i,
  input  logic [WORD_W*PRIO_W-1:0] prio_i,
  input  prio_t                    thr_i,
  output logic [WORD_W-1:0]        qual_o,
  output logic                     any_o
);
  for (genvar j = 0; j < WORD_W; j++) begin : g_bit
    if (BASE + j == 0) begin : g_rsvd
      assign qual_o[j] = 1'b0;
    end else begin : g_src
      prio_t p;
      assign p         = prio_i[j*PRIO_W +: PRIO_W];
      assign qual_o[j] = pend_i[j] & ~claim_i[j] & en_i[j] & (p > thr_i);
    end
  end

  assign any_o = |qual_o;
endmodule

// File: rtl/irq_sel_tree.sv
module irq_sel_tree
  import irq_sel_pkg::*;
#(
  parameter int unsigned N    = 32,
  parameter int unsigned ID_W = 6
) (
  input  logic            vld_i  [N],
  input  prio_t           prio_i [N],
  input  logic [ID_W-1:0] id_i   [N],
  output logic            vld_o,
  output prio_t           prio_o,
  output logic [ID_W-1:0] id_o
);
  localparam int unsigned LVL    = $clog2(N);
  localparam int unsigned LEAVES = 1 << LVL;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic            nv [1:NODES];
  prio_t           np [1:NODES];
  logic [ID_W-1:0] ni [1:NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nv[LEAVES+i] = vld_i[i];
      assign np[LEAVES+i] = prio_i[i];
      assign ni[LEAVES+i] = id_i[i];
    end else begin : g_pad
      assign nv[LEAVES+i] = 1'b0;
      assign np[LEAVES+i] = '0;
      assign ni[LEAVES+i] = '0;
    end
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_r;
    assign take_r = right_wins(nv[2*n], np[2*n], nv[2*n+1], np[2*n+1]);
    assign nv[n]  = nv[2*n] | nv[2*n+1];
    assign np[n]  = take_r ? np[2*n+1] : np[2*n];
    assign ni[n]  = take_r ? ni[2*n+1] : ni[2*n];
  end

  assign vld_o  = nv[1];
  assign prio_o = np[1];
  assign id_o   = ni[1];
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned NUM_SRC = 53,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        claim_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic                      irq_o,
  output logic [ID_W-1:0]           id_o,
  output logic                      valid_o
);
  localparam int unsigned WORDS   = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned SRC_PAD = WORDS * WORD_W;

  logic [SRC_PAD-1:0]        pend_pad, claim_pad, en_pad;
  logic [SRC_PAD*PRIO_W-1:0] prio_pad;

  always_comb begin
    pend_pad  = '0;
    claim_pad = '0;
    en_pad    = '0;
    prio_pad  = '0;
    pend_pad[NUM_SRC-1:0]         = pend_i;
    claim_pad[NUM_SRC-1:0]        = claim_i;
    en_pad[NUM_SRC-1:0]           = en_i;
    prio_pad[NUM_SRC*PRIO_W-1:0]  = prio_i;
  end

  logic            w_vld  [WORDS];
  prio_t           w_prio [WORDS];
  logic [ID_W-1:0] w_id   [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] qual;
    logic              any;
    logic              b_vld  [WORD_W];
    prio_t             b_prio [WORD_W];
    logic [ID_W-1:0]   b_id   [WORD_W];
    logic              t_vld;
    prio_t             t_prio;
    logic [ID_W-1:0]   t_id;

    irq_word_mask #(.BASE(w*WORD_W)) u_mask (
      .pend_i (pend_pad[w*WORD_W +: WORD_W]),
      .claim_i(claim_pad[w*WORD_W +: WORD_W]),
      .en_i   (en_pad[w*WORD_W +: WORD_W]),
      .prio_i (prio_pad[w*WORD_W*PRIO_W +: WORD_W*PRIO_W]),
      .thr_i  (thr_i),
      .qual_o (qual),
      .any_o  (any)
    );

    for (genvar j = 0; j < WORD_W; j++) begin : g_leaf
      assign b_vld[j]  = qual[j];
      assign b_prio[j] = prio_pad[(w*WORD_W+j)*PRIO_W +: PRIO_W];
      assign b_id[j]   = ID_W'(w*WORD_W + j);
    end

    irq_sel_tree #(.N(WORD_W), .ID_W(ID_W)) u_tree (
      .vld_i (b_vld),
      .prio_i(b_prio),
      .id_i  (b_id),
      .vld_o (t_vld),
      .prio_o(t_prio),
      .id_o  (t_id)
    );

    // empty word drops out of the cross-word stage
    assign w_vld[w]  = any & t_vld;
    assign w_prio[w] = t_prio;
    assign w_id[w]   = t_id;
  end

  logic            r_vld;
  prio_t           r_prio;
  logic [ID_W-1:0] r_id;

  irq_sel_tree #(.N(WORDS), .ID_W(ID_W)) u_top_tree (
    .vld_i (w_vld),
    .prio_i(w_prio),
    .id_i  (w_id),
    .vld_o (r_vld),
    .prio_o(r_prio),
    .id_o  (r_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      id_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      irq_o   <= r_vld;
      id_o    <= r_vld ? r_id : '0;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk #(
  parameter int unsigned NUM_SRC = 53,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_SRC-1:0]        pend_i,
  input logic [NUM_SRC-1:0]        claim_i,
  input logic [NUM_SRC-1:0]        en_i,
  input logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input logic [PRIO_W-1:0]         thr_i,
  input logic                      irq_o,
  input logic [ID_W-1:0]           id_o,
  input logic                      valid_o
);
  logic [NUM_SRC-1:0]        pend_d, claim_d, en_d;
  logic [NUM_SRC*PRIO_W-1:0] prio_d;
  logic [PRIO_W-1:0]         thr_d;

  always_ff @(posedge clk_i) begin
    pend_d  <= pend_i;
    claim_d <= claim_i;
    en_d    <= en_i;
    prio_d  <= prio_i;
    thr_d   <= thr_i;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset_out: assert (!irq_o && !valid_o && id_o == '0);
    end
  end

  a_r1_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_d[id_o] && !claim_d[id_o] && en_d[id_o]));

  a_r2_above_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (prio_d[id_o*PRIO_W +: PRIO_W] > thr_d));

  a_r6_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (id_o == '0));

  a_r7_no_src0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (id_o != '0));

  a_r8_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

bind irq_prio_sel irq_prio_sel_chk #(
  .NUM_SRC(NUM_SRC),
  .PRIO_W (irq_sel_pkg::PRIO_W),
  .ID_W   (ID_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pend_i (pend_i),
  .claim_i(claim_i),
  .en_i   (en_i),
  .prio_i (prio_i),
  .thr_i  (thr_i),
  .irq_o  (irq_o),
  .id_o   (id_o),
  .valid_o(valid_o)
);

// File: tb/irq_prio_sel_tb_top.sv
module irq_prio_sel_tb_top;
  localparam int N    = 53;
  localparam int PW   = 3;
  localparam int ID_W = $clog2(N);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]    pend, claim, en;
  logic [N*PW-1:0] prio;
  logic [PW-1:0]   thr;
  logic            irq_o, valid_o;
  logic [ID_W-1:0] id_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  irq_prio_sel #(.NUM_SRC(N)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .claim_i(claim),
    .en_i   (en),
    .prio_i (prio),
    .thr_i  (thr),
    .irq_o  (irq_o),
    .id_o   (id_o),
    .valid_o(valid_o)
  );

  // reference: upward scan, strict greater-than
  function automatic int ref_id(logic [N-1:0] p, logic [N-1:0] c, logic [N-1:0] e,
                                logic [N*PW-1:0] pr, logic [PW-1:0] t);
    int best = 0;
    int bp   = int'(t);
    for (int s = 1; s < N; s++) begin
      if (p[s] && !c[s] && e[s] && int'(pr[s*PW +: PW]) > bp) begin
        best = s;
        bp   = int'(pr[s*PW +: PW]);
      end
    end
    return best;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    pend = '0; claim = '0; en = '0; prio = '0; thr = '0;
  endtask

  task automatic set_src(int s, logic [PW-1:0] p);
    pend[s] = 1'b1;
    en[s]   = 1'b1;
    prio[s*PW +: PW] = p;
  endtask

  // inputs already set at a negedge; advance one edge, check at the following negedge
  task automatic step_check(string req_irq, string req_id);
    int e;
    e = ref_id(pend, claim, en, prio, thr);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req_irq, int'(irq_o), int'(e != 0));
    chk(req_id, int'(id_o), e);
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev;
    void'($urandom(32'd20240611));
    clear_in();
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 irq", int'(irq_o), 0);
    chk("R9 id", int'(id_o), 0);
    chk("R9 valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 valid", int'(valid_o), 1);
    chk("R6 none irq", int'(irq_o), 0);
    chk("R6 none id", int'(id_o), 0);

    // R2 equal to threshold does not count
    clear_in(); set_src(5, 3'd4); thr = 3'd4;
    step_check("R2 equal irq", "R2 equal id");
    chk("R2 equal blocks", int'(irq_o), 0);
    thr = 3'd3;
    step_check("R2 above irq", "R2 above id");
    chk("R2 above wins", int'(id_o), 5);

    // R1 claimed or disabled blocks
    claim[5] = 1'b1;
    step_check("R1 claimed irq", "R1 claimed id");
    chk("R1 claimed blocks", int'(irq_o), 0);
    claim[5] = 1'b0; en[5] = 1'b0;
    step_check("R1 disabled irq", "R1 disabled id");
    chk("R1 disabled blocks", int'(irq_o), 0);

    // R5 tie across words, R4 higher priority wins
    clear_in(); set_src(40, 3'd6); set_src(10, 3'd6); set_src(33, 3'd6); thr = 3'd1;
    step_check("R5 tie irq", "R5 tie id");
    chk("R5 tie lowest", int'(id_o), 10);
    prio[40*PW +: PW] = 3'd7;
    step_check("R4 high irq", "R4 high id");
    chk("R4 high wins", int'(id_o), 40);

    // R7 source 0 ignored
    clear_in(); set_src(0, 3'd7); thr = 3'd0;
    step_check("R7 src0 irq", "R7 src0 id");
    chk("R7 src0 ignored", int'(irq_o), 0);

    // R10 top source in partial last word
    clear_in(); set_src(N-1, 3'd1); set_src(31, 3'd1); set_src(32, 3'd2); thr = 3'd0;
    step_check("R10 top irq", "R10 top id");
    chk("R10 word1 wins", int'(id_o), 32);
    prio[32*PW +: PW] = 3'd0;
    prio[31*PW +: PW] = 3'd0;
    step_check("R10 last irq", "R10 last id");
    chk("R10 last src", int'(id_o), N-1);

    // R8 outputs hold until the next edge
    prev = int'(id_o);
    clear_in(); set_src(7, 3'd5);
    #1;
    chk("R8 hold id", int'(id_o), prev);
    step_check("R8 next irq", "R8 next id");

    // random patterns, density varied
    for (int it = 0; it < 600; it++) begin
      logic [63:0] a, b, c;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      c = {$urandom, $urandom};
      case (it % 3)
        0: pend = N'(a & b & c);
        1: pend = N'(a & b);
        default: pend = N'(a | b);
      endcase
      claim = N'({$urandom, $urandom} & {$urandom, $urandom});
      en    = N'({$urandom, $urandom} | {$urandom, $urandom});
      for (int s = 0; s < N; s++) prio[s*PW +: PW] = PW'($urandom);
      thr = PW'($urandom);
      step_check("R3 rand irq", "R4 rand id");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule